// File: doc/BRIEF.md
# Detector Configuration Load Sequencer

This block loads a configuration word into one of several detector channels from a serial bit stream. A one-cycle `arm_i` strobe starts it. The strobe comes from an address match upstream. After it, the block samples the next few serial bits as a bandwidth code. It then counts clock cycles up to a fixed event count. At that count it runs a three-step sequence: take the sensitivity bit, store into the channel picked by `chan_addr_i`, and clear back to idle.

Each channel keeps its stored code and sensitivity bit until it is written again. The code is decoded into a one-hot bandwidth select for that channel. The channel that is written gets a one-clock reset strobe, which the analog side uses to dump its integrator.

The sequencer has six states, in this order:
- IDLE waits for the strobe.
- CAPTURE shifts in the code bits.
- COUNT waits for the event count.
- SENSE takes the sensitivity bit.
- STORE writes the channel and fires its reset.
- CLEAR returns to IDLE.

The transitions are:
- IDLE to CAPTURE on `arm_i`.
- CAPTURE to COUNT once the counter equals CODE_W.
- COUNT to SENSE once the counter equals FIRE_COUNT.
- SENSE to STORE, STORE to CLEAR and CLEAR to IDLE, each taking one cycle with no condition.

Top module: `det_cfg_loader`

## Requirements
- R1: After reset, `armed_o` is 0, `sens_o` and `chan_rst_o` are all 0, and every channel's bandwidth select has only its bit 0 set (stored code 0).
- R2: `arm_i` high at a clock edge in IDLE sets `armed_o` from that edge. `arm_i` is ignored while `armed_o` is 1.
- R3: Call the arming edge edge 0. The serial bits sampled at edges 1 to CODE_W (3 by default) form the code, and the bit at edge 1 is the most significant.
- R4: Serial bits sampled at any other edge do not change the stored code, and neither do serial bits sampled in IDLE.
- R5: The sensitivity bit is the serial bit sampled at edge FIRE_COUNT+1 (51 by default).
- R6: At edge FIRE_COUNT+2, the code and sensitivity bit are written into channel `chan_addr_i`, sampled at that edge (value k selects channel k). No output changes earlier.
- R7: `chan_rst_o` has exactly the written channel's bit high for one cycle, starting at the store edge. At all other times it is 0.
- R8: Channels that are not written keep their code and sensitivity bit.
- R9: Channel i's bandwidth select is `bw_sel_o[i*8 +: 8]`, and only bit c is set when the stored code is c. `sens_o[i]` is that channel's stored sensitivity bit.
- R10: `armed_o` falls at edge FIRE_COUNT+3. A new `arm_i` is accepted at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which is also the serial bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start strobe from the address match |
| ser_i | input | 1 | Serial data bit, one per clock |
| chan_addr_i | input | 2 | Target channel, sampled at the store edge |
| armed_o | output | 1 | High while a load sequence is running |
| bw_sel_o | output | 32 | One-hot bandwidth select, 8 bits per channel |
| sens_o | output | 4 | Sensitivity bit per channel |
| chan_rst_o | output | 4 | One-cycle integrator reset per channel |

## Verification
All timing is counted from the arming edge, edge 0:
- The code bits are due at edges 1 to 3.
- The sensitivity bit is taken at edge 51.
- The store, the new bandwidth select and sensitivity, and the reset strobe all appear at edge 52.
- `armed_o` falls at edge 53.

The bench drives each input on the falling edge just before the rising edge that samples it, and it counts rising edges from the arming edge. It reads the outputs on the falling edge that follows the edge where a result is due. It also checks at edge 51 that no output has moved yet, and at edge 53 that the reset strobe has ended.

// File: rtl/det_cfg_pkg.sv
package det_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_COUNT,
        ST_SENSE,
        ST_STORE,
        ST_CLEAR
    } seq_state_e;
endpackage

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import det_cfg_pkg::*;
#(
    parameter int CODE_W     = 3,
    parameter int FIRE_COUNT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              ser_i,
    output logic              armed_o,
    output logic              wr_en_o,
    output logic [CODE_W-1:0] code_o,
    output logic              sens_o
);
    localparam int CNT_W = $clog2(FIRE_COUNT + 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] code_q;
    logic              sens_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm_i) state_d = ST_CAPTURE;
            ST_CAPTURE: if (cnt_q == CNT_W'(CODE_W)) state_d = ST_COUNT;
            ST_COUNT:   if (cnt_q == CNT_W'(FIRE_COUNT)) state_d = ST_SENSE;
            ST_SENSE:   state_d = ST_STORE;
            ST_STORE:   state_d = ST_CLEAR;
            ST_CLEAR:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter and capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
            sens_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:    cnt_q <= arm_i ? CNT_W'(1) : '0;
                ST_CAPTURE: begin
                    code_q <= {code_q[CODE_W-2:0], ser_i};
                    cnt_q  <= cnt_q + 1'b1;
                end
                ST_COUNT:   cnt_q  <= cnt_q + 1'b1;
                ST_SENSE:   sens_q <= ser_i;
                ST_STORE:   cnt_q  <= cnt_q;
                ST_CLEAR:   cnt_q  <= '0;
                default:    cnt_q  <= '0;
            endcase
        end
    end

    assign armed_o = (state_q != ST_IDLE);
    assign wr_en_o = (state_q == ST_STORE);
    assign code_o  = code_q;
    assign sens_o  = sens_q;
endmodule

// File: rtl/cfg_chan_bank.sv
module cfg_chan_bank #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 3,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic                     sens_i,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        sens_o,
    output logic [NUM_CH-1:0]        rst_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = wr_en_i && (addr_i == ADDR_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_o[i*CODE_W +: CODE_W] <= '0;
                sens_o[i]                  <= 1'b0;
                rst_o[i]                   <= 1'b0;
            end else begin
                rst_o[i] <= sel;
                if (sel) begin
                    code_o[i*CODE_W +: CODE_W] <= code_i;
                    sens_o[i]                  <= sens_i;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_bw_decode.sv
module cfg_bw_decode #(
    parameter int CODE_W = 3,
    parameter int BW_W   = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [BW_W-1:0]   sel_o
);
    always_comb begin
        sel_o = '0;
        sel_o[code_i] = 1'b1;
    end
endmodule

// File: rtl/det_cfg_loader.sv
module det_cfg_loader #(
    parameter int NUM_CH     = 4,
    parameter int CODE_W     = 3,
    parameter int FIRE_COUNT = 50,
    parameter int ADDR_W     = $clog2(NUM_CH),
    parameter int BW_W       = 1 << CODE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm_i,
    input  logic                   ser_i,
    input  logic [ADDR_W-1:0]      chan_addr_i,
    output logic                   armed_o,
    output logic [NUM_CH*BW_W-1:0] bw_sel_o,
    output logic [NUM_CH-1:0]      sens_o,
    output logic [NUM_CH-1:0]      chan_rst_o
);
    logic                     wr_en;
    logic [CODE_W-1:0]        cap_code;
    logic                     cap_sens;
    logic [NUM_CH*CODE_W-1:0] ch_code;

    cfg_seq_fsm #(
        .CODE_W    (CODE_W),
        .FIRE_COUNT(FIRE_COUNT)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm_i),
        .ser_i  (ser_i),
        .armed_o(armed_o),
        .wr_en_o(wr_en),
        .code_o (cap_code),
        .sens_o (cap_sens)
    );

    cfg_chan_bank #(
        .NUM_CH(NUM_CH),
        .CODE_W(CODE_W),
        .ADDR_W(ADDR_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_en),
        .addr_i (chan_addr_i),
        .code_i (cap_code),
        .sens_i (cap_sens),
        .code_o (ch_code),
        .sens_o (sens_o),
        .rst_o  (chan_rst_o)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        cfg_bw_decode #(
            .CODE_W(CODE_W),
            .BW_W  (BW_W)
        ) u_dec (
            .code_i(ch_code[i*CODE_W +: CODE_W]),
            .sel_o (bw_sel_o[i*BW_W +: BW_W])
        );
    end
endmodule

// File: rtl/det_cfg_loader_chk.sv
module det_cfg_loader_chk #(
    parameter int NUM_CH = 4,
    parameter int BW_W   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   armed_o,
    input logic [NUM_CH*BW_W-1:0] bw_sel_o,
    input logic [NUM_CH-1:0]      sens_o,
    input logic [NUM_CH-1:0]      chan_rst_o
);
    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(chan_rst_o)); // R7
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (chan_rst_o != '0) |=> (chan_rst_o == '0)); // R7
    AST_RST_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n) (chan_rst_o != '0) |-> armed_o); // R6

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        AST_BW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(bw_sel_o[i*BW_W +: BW_W]) == 1); // R9
        AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n) !chan_rst_o[i] |-> ($stable(bw_sel_o[i*BW_W +: BW_W]) && $stable(sens_o[i]))); // R8
    end
endmodule

bind det_cfg_loader det_cfg_loader_chk #(
    .NUM_CH(NUM_CH),
    .BW_W  (BW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed_o   (armed_o),
    .bw_sel_o  (bw_sel_o),
    .sens_o    (sens_o),
    .chan_rst_o(chan_rst_o)
);

// File: tb/sim_det_cfg_loader.sv
module sim_det_cfg_loader;
    localparam int FIRE = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic        ser_i = 1'b0;
    logic [1:0]  chan_addr_i = 2'd0;
    logic        armed_o;
    logic [31:0] bw_sel_o;
    logic [3:0]  sens_o;
    logic [3:0]  chan_rst_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] m_code [4];
    logic [3:0] m_sens;

    always #5 clk = ~clk;

    det_cfg_loader #(.FIRE_COUNT(FIRE)) u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .ser_i(ser_i),
        .chan_addr_i(chan_addr_i), .armed_o(armed_o), .bw_sel_o(bw_sel_o),
        .sens_o(sens_o), .chan_rst_o(chan_rst_o)
    );

    function automatic logic [31:0] exp_bw();
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) v[i*8 + int'(m_code[i])] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One full load: arming edge is edge 0, inputs set on the falling edge before each edge
    task automatic do_load(logic [2:0] code, logic sens, logic [1:0] addr, bit noise);
        @(negedge clk);
        arm_i = 1'b1;
        ser_i = $urandom_range(1);
        @(posedge clk);
        for (int n = 1; n <= FIRE + 2; n++) begin
            @(negedge clk);
            if (n == 1) chk("R2 armed after arm", 64'(armed_o), 64'd1);
            if (n == FIRE + 1) begin
                chk("R6 no early bw update", 64'(bw_sel_o), 64'(exp_bw()));
                chk("R6 no early sens update", 64'(sens_o), 64'(m_sens));
                chk("R7 no early reset", 64'(chan_rst_o), 64'd0);
            end
            arm_i = noise ? 1'($urandom_range(1)) : 1'b0;
            if (n <= 3)             ser_i = code[3-n];
            else if (n == FIRE + 1) ser_i = sens;
            else                    ser_i = $urandom_range(1);
            chan_addr_i = (n == FIRE + 2) ? addr : 2'($urandom_range(3));
            @(posedge clk);
        end
        @(negedge clk);
        m_code[addr] = code;
        m_sens[addr] = sens;
        chk("R7 reset strobe on store", 64'(chan_rst_o), 64'(4'b1 << addr));
        chk("R3 R9 bw select after store", 64'(bw_sel_o), 64'(exp_bw()));
        chk("R5 R8 sens after store", 64'(sens_o), 64'(m_sens));
        chk("R10 still armed at store", 64'(armed_o), 64'd1);
        arm_i = noise ? 1'($urandom_range(1)) : 1'b0;
        ser_i = $urandom_range(1);
        @(posedge clk);
        @(negedge clk);
        arm_i = 1'b0;
        chk("R7 reset one cycle", 64'(chan_rst_o), 64'd0);
        chk("R10 disarmed after clear", 64'(armed_o), 64'd0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) m_code[i] = 3'd0;
        m_sens = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset armed", 64'(armed_o), 64'd0);
        chk("R1 reset bw", 64'(bw_sel_o), 64'h01010101);
        chk("R1 reset sens", 64'(sens_o), 64'd0);
        chk("R1 reset strobe", 64'(chan_rst_o), 64'd0);

        // R4: serial activity while idle changes nothing
        for (int k = 0; k < 20; k++) begin
            ser_i = $urandom_range(1);
            chan_addr_i = 2'($urandom_range(3));
            @(posedge clk);
            @(negedge clk);
        end
        chk("R4 idle bw", 64'(bw_sel_o), 64'(exp_bw()));
        chk("R4 idle armed", 64'(armed_o), 64'd0);

        // directed corners: each channel, extreme codes, back-to-back starts
        do_load(3'b111, 1'b1, 2'd3, 1'b0);
        do_load(3'b100, 1'b0, 2'd0, 1'b0);
        do_load(3'b001, 1'b1, 2'd1, 1'b1);
        do_load(3'b000, 1'b1, 2'd2, 1'b1);
        do_load(3'b110, 1'b0, 2'd3, 1'b0);

        // constrained random loads with arm noise while busy (R2)
        for (int k = 0; k < 30; k++)
            do_load(3'($urandom_range(7)), 1'($urandom_range(1)),
                    2'($urandom_range(3)), 1'b1);

        chk("R8 final bw", 64'(bw_sel_o), 64'(exp_bw()));
        chk("R8 final sens", 64'(sens_o), 64'(m_sens));
        summary();
    end
endmodule